// File: doc/BRIEF.md
# Manchester Line Receiver with Preamble Removal

This block takes a single-bit Manchester-coded serial line, sampled by the local clock at a fixed multiple of the bit rate. It recovers the bit timing from the guaranteed mid-cell transitions and turns the line into a stream of frame bytes. Each bit cell carries the complement of the bit in its first half and the bit itself in its second half. The mid-cell transition therefore gives the bit value: a rising transition is a '1' and a falling transition is a '0'. No separate clock travels with the data. A counter in the receiver re-centres itself on every accepted mid-cell transition. It ignores the optional transitions at cell boundaries with a blanking window.

A frame begins with a run of alternating bits and ends its lead-in with two consecutive '1' bits. The transmitter may lose any number of the leading bits, so the receiver never counts the lead-in. It declares lock once it has seen enough alternation, then waits for the double '1'. Everything up to and including the double '1' is discarded. The bits that follow are packed least significant bit first into bytes. Each byte is presented for one cycle, and the first byte of the frame is marked. When a mid-cell transition fails to appear inside a frame, the receiver reports a coding violation. A quiet line lasting more than two bit times closes the frame with an end marker, and the receiver returns to searching. The normal end of a transmission therefore shows up as one violation followed by the end marker.

Top module: `manch_rx`

## Requirements
- R1: A rising mid-cell transition (low first half, high second half) decodes as bit '1'. A falling mid-cell transition (high then low) decodes as bit '0'.
- R2: With the default of 8 samples per bit, the receiver decodes correctly when the transmitter's bit cell is anywhere from 7 to 9 samples long. Every accepted transition restarts the timing. Transitions arriving fewer than 6 samples after an accepted one are ignored.
- R3: `lock_o` rises only after at least 8 consecutive alternating bits. A lead-in of 7 or fewer alternating bits, counting the first '1' of the start marker, produces no lock and no output bytes.
- R4: A truncated lead-in of any length that satisfies R3 is accepted. The receiver's behaviour does not depend on the total lead-in length.
- R5: After lock, two consecutive '1' bits end the lead-in. No lead-in bit, and no bit of the start marker, appears in an output byte.
- R6: The bit after the second '1' of the marker is bit 0 of the first byte, and bits fill in from least significant to most significant. `byte_vld_o` is a one-cycle pulse per completed byte, and no two pulses fall in consecutive cycles. `sof_o` is high with the first byte of a frame only.
- R7: When a frame is in progress and 12 samples pass without a mid-cell transition, `cviol_o` pulses once for one cycle. While the receiver is not locked, `cviol_o` stays low.
- R8: When a frame is in progress and 17 samples pass with no transition, `eof_o` pulses for one cycle and `lock_o` falls. A partly assembled byte is discarded.
- R9: While reset is applied, and after its release, `byte_vld_o`, `sof_o`, `eof_o`, `cviol_o` and `lock_o` are all low.
- R10: No more than one of `byte_vld_o`, `eof_o` and `cviol_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, 8 times the line bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Asynchronous Manchester-coded line |
| byte_o | output | 8 | Received frame byte |
| byte_vld_o | output | 1 | One-cycle strobe for `byte_o` |
| sof_o | output | 1 | First byte of the frame, valid with `byte_vld_o` |
| eof_o | output | 1 | One-cycle end-of-frame pulse |
| cviol_o | output | 1 | One-cycle coding-violation pulse |
| lock_o | output | 1 | Receiver is locked to the lead-in or is inside a frame |

## Verification
The assertions check, on every cycle, that the output events relate to one another correctly. They check that bytes and violations appear only while locked, that the start marker rides on a byte strobe, that strobes never fall back to back, that the end marker drops lock, and that no two events coincide. The decoded byte values, the bit order, the removal of the lead-in, and the lock threshold at its exact boundary can only be shown by the bench. So can the tolerance to cells 7 or 9 samples long and the loss of a trailing partial byte. The bench builds whole frames with a scoreboard and compares the bytes, the violation count and the end markers after each frame.

// File: rtl/manch_rx_pkg.sv
package manch_rx_pkg;

  typedef enum logic [1:0] {
    FR_HUNT = 2'd0,
    FR_LOCK = 2'd1,
    FR_DATA = 2'd2
  } fr_state_t;

  // one decoded event from the bit timer, all fields one cycle wide
  typedef struct packed {
    logic vld;   // mid-cell transition accepted, val is the bit
    logic val;
    logic miss;  // mid-cell transition overdue
    logic idle;  // line quiet beyond the idle limit
  } bit_evt_t;

endpackage

// File: rtl/manch_rx_edge.sv
module manch_rx_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic lvl_o,
  output logic edge_o
);

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   prev_q, prev_d;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], line_i};
    prev_d = sync_q[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign lvl_o  = sync_q[SYNC_STAGES-1];
  assign edge_o = sync_q[SYNC_STAGES-1] ^ prev_q;

endmodule

// File: rtl/manch_rx_bittimer.sv
module manch_rx_bittimer
  import manch_rx_pkg::*;
#(
  parameter int OSR = 8
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     lvl_i,
  input  logic     edge_i,
  output bit_evt_t evt_o
);

  localparam int BLANK    = OSR - OSR / 4;      // boundary edges fall before this
  localparam int MISS_LIM = OSR + OSR / 2;      // mid-cell edge overdue
  localparam int IDLE_LIM = 2 * OSR + 1;        // more than two bit times
  localparam int CW       = $clog2(IDLE_LIM + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  bit_evt_t      evt_q, evt_d;
  logic          accept;

  always_comb begin
    accept = edge_i && (cnt_q >= CW'(BLANK));
    if (accept)
      cnt_d = CW'(1);
    else if (cnt_q == CW'(IDLE_LIM))
      cnt_d = cnt_q;
    else
      cnt_d = cnt_q + CW'(1);
    evt_d.vld  = accept;
    evt_d.val  = lvl_i;
    evt_d.miss = !accept && (cnt_q == CW'(MISS_LIM - 1));
    evt_d.idle = !accept && (cnt_q == CW'(IDLE_LIM - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CW'(IDLE_LIM);
      evt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      evt_q <= evt_d;
    end
  end

  assign evt_o = evt_q;

endmodule

// File: rtl/manch_rx_framer.sv
module manch_rx_framer
  import manch_rx_pkg::*;
#(
  parameter int LOCK_MIN = 8,
  parameter int BYTE_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bit_evt_t          evt_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_vld_o,
  output logic              sof_o,
  output logic              eof_o,
  output logic              cviol_o,
  output logic              lock_o
);

  localparam int RUN_W = $clog2(LOCK_MIN + 1);
  localparam int BCW   = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;

  fr_state_t         st_q, st_d;
  logic [RUN_W-1:0]  run_q, run_d, run_inc;
  logic              prev_q, prev_d;
  logic [BCW-1:0]    bcnt_q, bcnt_d;
  logic              first_q, first_d;
  logic [BYTE_W-1:0] sr_q, sr_d, sr_nx;
  logic [BYTE_W-1:0] byte_q, byte_d;
  logic              bvld_q, bvld_d;
  logic              sof_q, sof_d;
  logic              eof_q, eof_d;
  logic              cv_q, cv_d;

  always_comb begin
    st_d    = st_q;
    run_d   = run_q;
    prev_d  = prev_q;
    bcnt_d  = bcnt_q;
    first_d = first_q;
    sr_d    = sr_q;
    byte_d  = byte_q;
    bvld_d  = 1'b0;
    sof_d   = 1'b0;
    eof_d   = 1'b0;
    cv_d    = 1'b0;
    run_inc = (run_q == RUN_W'(LOCK_MIN)) ? run_q : run_q + RUN_W'(1);
    sr_nx   = {evt_i.val, sr_q[BYTE_W-1:1]};

    unique case (st_q)
      FR_HUNT: begin
        if (evt_i.vld) begin
          prev_d = evt_i.val;
          if (run_q != '0 && evt_i.val != prev_q) begin
            run_d = run_inc;
            if (run_inc >= RUN_W'(LOCK_MIN)) st_d = FR_LOCK;
          end else begin
            run_d = RUN_W'(1);
          end
        end else if (evt_i.miss || evt_i.idle) begin
          run_d = '0;
        end
      end
      FR_LOCK: begin
        if (evt_i.vld) begin
          prev_d = evt_i.val;
          if (evt_i.val == prev_q) begin
            if (evt_i.val) begin
              st_d    = FR_DATA;
              bcnt_d  = '0;
              first_d = 1'b1;
            end else begin
              st_d  = FR_HUNT;
              run_d = RUN_W'(1);
            end
          end
        end else if (evt_i.miss || evt_i.idle) begin
          st_d  = FR_HUNT;
          run_d = '0;
        end
      end
      FR_DATA: begin
        if (evt_i.vld) begin
          sr_d = sr_nx;
          if (bcnt_q == BCW'(BYTE_W - 1)) begin
            byte_d  = sr_nx;
            bvld_d  = 1'b1;
            sof_d   = first_q;
            first_d = 1'b0;
            bcnt_d  = '0;
          end else begin
            bcnt_d = bcnt_q + BCW'(1);
          end
        end else if (evt_i.miss) begin
          cv_d = 1'b1;
        end else if (evt_i.idle) begin
          eof_d = 1'b1;
          st_d  = FR_HUNT;
          run_d = '0;
        end
      end
      default: begin
        st_d  = FR_HUNT;
        run_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= FR_HUNT;
      run_q   <= '0;
      prev_q  <= 1'b0;
      bcnt_q  <= '0;
      first_q <= 1'b0;
      sr_q    <= '0;
      byte_q  <= '0;
      bvld_q  <= 1'b0;
      sof_q   <= 1'b0;
      eof_q   <= 1'b0;
      cv_q    <= 1'b0;
    end else begin
      st_q    <= st_d;
      run_q   <= run_d;
      prev_q  <= prev_d;
      bcnt_q  <= bcnt_d;
      first_q <= first_d;
      sr_q    <= sr_d;
      byte_q  <= byte_d;
      bvld_q  <= bvld_d;
      sof_q   <= sof_d;
      eof_q   <= eof_d;
      cv_q    <= cv_d;
    end
  end

  assign byte_o     = byte_q;
  assign byte_vld_o = bvld_q;
  assign sof_o      = sof_q;
  assign eof_o      = eof_q;
  assign cviol_o    = cv_q;
  assign lock_o     = (st_q != FR_HUNT);

endmodule

// File: rtl/manch_rx.sv
module manch_rx
  import manch_rx_pkg::*;
#(
  parameter int OSR         = 8,
  parameter int LOCK_MIN    = 8,
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_vld_o,
  output logic              sof_o,
  output logic              eof_o,
  output logic              cviol_o,
  output logic              lock_o
);

  // reset asserts at once, releases on a clock edge
  logic [1:0] rst_sq;
  logic       rst_li_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sq <= 2'b00;
    else        rst_sq <= {rst_sq[0], 1'b1};
  end
  assign rst_li_n = rst_sq[1];

  logic     lvl, edg;
  bit_evt_t evt;

  manch_rx_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk    (clk),
    .rst_n  (rst_li_n),
    .line_i (line_i),
    .lvl_o  (lvl),
    .edge_o (edg)
  );

  manch_rx_bittimer #(.OSR(OSR)) u_timer (
    .clk    (clk),
    .rst_n  (rst_li_n),
    .lvl_i  (lvl),
    .edge_i (edg),
    .evt_o  (evt)
  );

  manch_rx_framer #(.LOCK_MIN(LOCK_MIN), .BYTE_W(BYTE_W)) u_framer (
    .clk        (clk),
    .rst_n      (rst_li_n),
    .evt_i      (evt),
    .byte_o     (byte_o),
    .byte_vld_o (byte_vld_o),
    .sof_o      (sof_o),
    .eof_o      (eof_o),
    .cviol_o    (cviol_o),
    .lock_o     (lock_o)
  );

endmodule

// File: rtl/manch_rx_chk.sv
module manch_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic byte_vld,
  input logic sof,
  input logic eof,
  input logic cviol,
  input logic lock
);

  assert_byte_in_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> lock);

  assert_sof_on_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sof |-> byte_vld);

  assert_no_back_to_back_R6: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |=> !byte_vld);

  assert_cviol_in_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cviol |-> lock);

  assert_eof_drops_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    eof |-> (!lock && $past(lock)));

  assert_events_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({byte_vld, eof, cviol}));

  assert_reset_quiet_R9: assert property (@(posedge clk)
    !rst_n |=> !(byte_vld || sof || eof || cviol || lock));

endmodule

bind manch_rx manch_rx_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .byte_vld (byte_vld_o),
  .sof      (sof_o),
  .eof      (eof_o),
  .cviol    (cviol_o),
  .lock     (lock_o)
);

// File: tb/manch_rx_bench.sv
module manch_rx_bench;

  logic       clk;
  logic       rst_n;
  logic       line_i;
  logic [7:0] byte_o;
  logic       byte_vld_o, sof_o, eof_o, cviol_o, lock_o;

  int n_chk  = 0;
  int n_fail = 0;
  int n_eof  = 0;
  int n_cv   = 0;
  bit done   = 0;

  logic [8:0] exp_q[$];   // {sof, byte}

  manch_rx u_manch_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_i     (line_i),
    .byte_o     (byte_o),
    .byte_vld_o (byte_vld_o),
    .sof_o      (sof_o),
    .eof_o      (eof_o),
    .cviol_o    (cviol_o),
    .lock_o     (lock_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every byte strobe (R1 R5 R6)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (byte_vld_o) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3/R5 unexpected byte", {23'd0, sof_o, byte_o}, 0);
        end else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          check({sof_o, byte_o} == e, "R1/R5/R6 byte", {23'd0, sof_o, byte_o}, {23'd0, e});
        end
      end
      if (eof_o) n_eof++;
      if (cviol_o) n_cv++;
    end
  end

  task automatic send_bit(input logic b, input int h1, input int h2);
    line_i = ~b;
    repeat (h1) @(negedge clk);
    line_i = b;
    repeat (h2) @(negedge clk);
  endtask

  task automatic send_frame(input int npre, input int nb, input logic [7:0] d[8],
                            input int h1, input int h2, input int extra);
    int  e0, c0;
    bit  locks;
    logic b0;
    e0 = n_eof;
    c0 = n_cv;
    locks = (npre + 1 >= 8);
    b0 = ((npre - 1) % 2 == 0) ? 1'b0 : 1'b1;
    line_i = ~b0;
    repeat (40) @(negedge clk);
    for (int i = 0; i < npre; i++)
      send_bit(((npre - 1 - i) % 2 == 0) ? 1'b0 : 1'b1, h1, h2);
    send_bit(1'b1, h1, h2);
    // second marker bit, first half: lock state reflects everything before it
    line_i = 1'b0;
    repeat (h1) @(negedge clk);
    check(lock_o == locks, "R3/R4 lock at marker", lock_o, locks);
    if (locks) begin
      for (int k = 0; k < nb; k++)
        exp_q.push_back({(k == 0), d[k]});
    end
    line_i = 1'b1;
    repeat (h2) @(negedge clk);
    for (int k = 0; k < nb; k++)
      for (int j = 0; j < 8; j++)
        send_bit(d[k][j], h1, h2);
    for (int j = 0; j < extra; j++)
      send_bit(j[0], h1, h2);
    repeat (5 * (h1 + h2)) @(negedge clk);
    check(exp_q.size() == 0, "R1/R6 all bytes delivered", exp_q.size(), 0);
    check(n_eof - e0 == int'(locks), "R8 end-of-frame pulse", n_eof - e0, int'(locks));
    check(n_cv - c0 == int'(locks), "R7 violation pulse", n_cv - c0, int'(locks));
    check(lock_o == 1'b0, "R8 lock dropped", lock_o, 0);
    exp_q.delete();
  endtask

  initial begin
    logic [7:0] d[8];
    rst_n  = 1'b0;
    line_i = 1'b0;
    repeat (4) @(negedge clk);
    check({byte_vld_o, sof_o, eof_o, cviol_o, lock_o} == 5'b0, "R9 in reset",
          {byte_vld_o, sof_o, eof_o, cviol_o, lock_o}, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check({byte_vld_o, sof_o, eof_o, cviol_o, lock_o} == 5'b0, "R9 after reset",
          {byte_vld_o, sof_o, eof_o, cviol_o, lock_o}, 0);

    // long lead-in, mixed bytes (R1 R5 R6)
    d = '{8'hA5, 8'h3C, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    send_frame(20, 4, d, 4, 4, 0);
    // shortest lead-in that locks (R3 R4)
    d = '{8'h01, 8'h80, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    send_frame(7, 2, d, 4, 4, 0);
    // one bit too short: nothing delivered (R3)
    d = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    send_frame(6, 2, d, 4, 4, 0);
    // fast transmitter, 7-sample cells (R2)
    d = '{8'h5A, 8'hC3, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    send_frame(11, 2, d, 3, 4, 0);
    // slow transmitter, 9-sample cells (R2 R4)
    d = '{8'h12, 8'h34, 8'h56, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    send_frame(9, 3, d, 4, 5, 0);
    // trailing partial byte dropped (R8 R7)
    d = '{8'hE7, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    send_frame(10, 1, d, 4, 4, 3);
    // idle line while hunting raises nothing (R7 R10)
    begin
      int c0;
      c0 = n_cv;
      line_i = ~line_i;
      repeat (60) @(negedge clk);
      check(n_cv == c0 && !lock_o, "R7 no violation while hunting", n_cv - c0, 0);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(negedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule